// File: doc/BRIEF.md
# Serial memory write-protect controller

This block guards the write paths of a serial non-volatile memory. It holds the write enable latch and decides, every cycle, whether a write or erase may reach the storage array and whether the status register may be rewritten. A serial command front end feeds it one-cycle event strobes for each decoded command: enable, disable, array write finished and status write finished. The status register supplies its lock bit and its two block-protect bits. The hardware write-protect pin, the target address and the busy flag of the self-timed write engine complete the inputs.

Array permission combines the latch, the busy flag and the block-protect range that contains the address. Status permission combines the latch, the busy flag, the lock bit and the protect pin. The block also gives a status byte view, so that the front end can return the latch and lock state on a status read.

Top module: `wp_guard`

## Requirements
- R1: After reset is asserted, `wel` is 0 and both `array_ok` and `stat_ok` are 0.
- R2: An `ev_wr_en` pulse with `busy` low sets `wel` at the next clock edge.
- R3: An `ev_wr_dis` pulse with `busy` low clears `wel` at the next clock edge.
- R4: An `ev_arr_done` or `ev_stat_done` pulse clears `wel` at the next clock edge. This holds whatever `busy` is, and a clear in the same cycle as `ev_wr_en` wins over the set.
- R5: While `wel` is 0, `array_ok` and `stat_ok` are both 0, for any `lock_en`, `wp_pin`, `blk_prot` and `addr`.
- R6: While `wel` is 1, `busy` is 0 and `lock_en` is 0, `stat_ok` is 1 whatever the value of `wp_pin`.
- R7: While `wel` is 1, `busy` is 0 and `lock_en` is 1, `stat_ok` equals `wp_pin` (1 means the pin is high).
- R8: `blk_prot` selects the protected range by comparing the top two address bits. 00 protects nothing. 01 protects addresses with top bits 11. 10 protects addresses with top bit 1. 11 protects every address. `array_ok` is 0 inside the range. Outside the range it is 1 when `wel` is 1 and `busy` is 0, regardless of `lock_en` and `wp_pin`.
- R9: While `busy` is 1, both permits are 0 and `ev_wr_en` and `ev_wr_dis` leave `wel` unchanged.
- R10: `stat_view` reports bit 0 = `busy`, bit 1 = `wel`, bits 3:2 = `blk_prot` and bit 7 = `lock_en`. Bits 6:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ev_wr_en | input | 1 | Write-enable command completed |
| ev_wr_dis | input | 1 | Write-disable command completed |
| ev_arr_done | input | 1 | Array write or erase finished |
| ev_stat_done | input | 1 | Status register write finished |
| lock_en | input | 1 | Status lock bit from the status register |
| wp_pin | input | 1 | Hardware write-protect pin, 1 = high |
| blk_prot | input | 2 | Block-protect code from the status register |
| addr | input | 16 | Target byte address |
| busy | input | 1 | Self-timed write cycle in progress |
| wel | output | 1 | Write enable latch |
| array_ok | output | 1 | Array write or erase permitted |
| stat_ok | output | 1 | Status register write permitted |
| stat_view | output | 8 | Status byte as seen on a read |

## Verification
The bench tests the exact edges of each protected range: 0xBFFF against 0xC000, and 0x7FFF against 0x8000. A decoder off by one range would grant a write into protected space or refuse a legal one. It drives an enable strobe together with a completion strobe, where a set-priority latch would wrongly stay armed after a write. It also sends enable and disable strobes while busy; a design that skips that guard would change the latch in the middle of a write cycle. Every lock and pin combination is covered, because a design that ignored the pin or ignored the lock bit would misreport `stat_ok`.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
  localparam int ADDR_W = 16;
  localparam int BP_W   = 2;
  localparam int TOP_W  = 2;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_code_e;

  typedef struct packed {
    logic set_req;
    logic clr_req;
  } latch_cmd_t;
endpackage

// File: rtl/wp_latch.sv
module wp_latch
  import wp_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  latch_cmd_t cmd,
  output logic       wel
);
  logic wel_q;
  logic wel_d;
  logic wel_en;

  always_comb begin
    wel_en = cmd.set_req | cmd.clr_req;
    wel_d  = wel_q;
    if (cmd.clr_req) begin
      wel_d = 1'b0;
    end else if (cmd.set_req) begin
      wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
    end else if (wel_en) begin
      wel_q <= wel_d;
    end
  end

  assign wel = wel_q;
endmodule

// File: rtl/wp_region.sv
module wp_region #(
  parameter int AW = 16,
  parameter int BW = 2
) (
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] code,
  output logic          hit
);
  localparam int TW     = BW;
  localparam int SLICES = 1 << TW;

  logic [TW-1:0] top_bits;
  logic [TW:0]   floor_idx;
  logic [SLICES-1:0] slice_prot;

  assign top_bits = addr[AW-1 -: TW];

  always_comb begin
    if (code == '0) begin
      floor_idx = (TW+1)'(SLICES);
    end else begin
      floor_idx = (TW+1)'(SLICES) - ((TW+1)'(1) << (code - 1'b1));
    end
  end

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    assign slice_prot[s] = ((TW+1)'(s) >= floor_idx);
  end

  assign hit = slice_prot[top_bits];
endmodule

// File: rtl/wp_permit.sv
module wp_permit (
  input  logic wel,
  input  logic busy,
  input  logic in_prot,
  input  logic lock_en,
  input  logic wp_pin,
  output logic array_ok,
  output logic stat_ok
);
  logic armed;
  logic stat_unlocked;

  always_comb begin
    armed         = wel & ~busy;
    stat_unlocked = ~lock_en | wp_pin;
    array_ok      = armed & ~in_prot;
    stat_ok       = armed & stat_unlocked;
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_guard_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_wr_en,
  input  logic          ev_wr_dis,
  input  logic          ev_arr_done,
  input  logic          ev_stat_done,
  input  logic          lock_en,
  input  logic          wp_pin,
  input  logic [BW-1:0] blk_prot,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  output logic          wel,
  output logic          array_ok,
  output logic          stat_ok,
  output logic [7:0]    stat_view
);
  latch_cmd_t cmd;
  logic       in_prot;

  always_comb begin
    cmd.set_req = ev_wr_en & ~busy;
    cmd.clr_req = ev_arr_done | ev_stat_done | (ev_wr_dis & ~busy);
  end

  wp_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .wel   (wel)
  );

  wp_region #(.AW(AW), .BW(BW)) u_region (
    .addr (addr),
    .code (blk_prot),
    .hit  (in_prot)
  );

  wp_permit u_permit (
    .wel      (wel),
    .busy     (busy),
    .in_prot  (in_prot),
    .lock_en  (lock_en),
    .wp_pin   (wp_pin),
    .array_ok (array_ok),
    .stat_ok  (stat_ok)
  );

  always_comb begin
    stat_view      = '0;
    stat_view[0]   = busy;
    stat_view[1]   = wel;
    stat_view[3:2] = blk_prot[1:0];
    stat_view[7]   = lock_en;
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int AW = 16,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_wr_en,
  input logic          ev_wr_dis,
  input logic          ev_arr_done,
  input logic          ev_stat_done,
  input logic          lock_en,
  input logic          wp_pin,
  input logic [BW-1:0] blk_prot,
  input logic [AW-1:0] addr,
  input logic          busy,
  input logic          wel,
  input logic          array_ok,
  input logic          stat_ok
);
  // R2
  set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_en && !busy && !ev_wr_dis && !ev_arr_done && !ev_stat_done) |=> wel);

  // R3
  dis_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_dis && !busy) |=> !wel);

  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arr_done || ev_stat_done) |=> !wel);

  // R5
  no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |-> (!array_ok && !stat_ok));

  // R7
  pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ok && lock_en) |-> wp_pin);

  // R8
  all_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_prot == '1) |-> !array_ok);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ev_arr_done && !ev_stat_done) |=> $stable(wel));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!array_ok && !stat_ok));
endmodule

bind wp_guard wp_guard_chk #(.AW(AW), .BW(BW)) u_chk (.*);

// File: tb/wp_guard_bench.sv
module wp_guard_bench;
  logic        clk;
  logic        rst_n;
  logic        ev_wr_en, ev_wr_dis, ev_arr_done, ev_stat_done;
  logic        lock_en, wp_pin, busy;
  logic [1:0]  blk_prot;
  logic [15:0] addr;
  logic        wel, array_ok, stat_ok;
  logic [7:0]  stat_view;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  wp_guard u_wp_guard (
    .clk(clk), .rst_n(rst_n),
    .ev_wr_en(ev_wr_en), .ev_wr_dis(ev_wr_dis),
    .ev_arr_done(ev_arr_done), .ev_stat_done(ev_stat_done),
    .lock_en(lock_en), .wp_pin(wp_pin), .blk_prot(blk_prot),
    .addr(addr), .busy(busy),
    .wel(wel), .array_ok(array_ok), .stat_ok(stat_ok), .stat_view(stat_view)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // fields: wel, lock, pin, bp[2], addr[16], busy, exp_array, exp_stat
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 2'b00, 16'h0000, 1'b0, 1'b0, 1'b0}, // R5
    {1'b0, 1'b1, 1'b1, 2'b00, 16'h1234, 1'b0, 1'b0, 1'b0}, // R5
    {1'b1, 1'b0, 1'b0, 2'b00, 16'hFFFF, 1'b0, 1'b1, 1'b1}, // R6
    {1'b1, 1'b0, 1'b1, 2'b00, 16'h0000, 1'b0, 1'b1, 1'b1}, // R6
    {1'b1, 1'b1, 1'b0, 2'b00, 16'h8000, 1'b0, 1'b1, 1'b0}, // R7
    {1'b1, 1'b1, 1'b1, 2'b00, 16'h8000, 1'b0, 1'b1, 1'b1}, // R7
    {1'b1, 1'b0, 1'b0, 2'b01, 16'hC000, 1'b0, 1'b0, 1'b1}, // R8
    {1'b1, 1'b0, 1'b0, 2'b01, 16'hBFFF, 1'b0, 1'b1, 1'b1}, // R8
    {1'b1, 1'b1, 1'b0, 2'b10, 16'h8000, 1'b0, 1'b0, 1'b0}, // R8
    {1'b1, 1'b1, 1'b1, 2'b10, 16'h7FFF, 1'b0, 1'b1, 1'b1}, // R8
    {1'b1, 1'b0, 1'b0, 2'b11, 16'h0000, 1'b0, 1'b0, 1'b1}, // R8
    {1'b1, 1'b1, 1'b1, 2'b11, 16'hFFFF, 1'b0, 1'b0, 1'b1}, // R8
    {1'b1, 1'b0, 1'b1, 2'b00, 16'h0000, 1'b1, 1'b0, 1'b0}  // R9
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ev_wr_en = 0; ev_wr_dis = 0; ev_arr_done = 0; ev_stat_done = 0;
  endtask

  // Drive one strobe cycle at a falling edge; the result is sampled at the next falling edge
  task automatic strobe(input bit en, input bit dis, input bit ad, input bit sd);
    @(negedge clk);
    ev_wr_en = en; ev_wr_dis = dis; ev_arr_done = ad; ev_stat_done = sd;
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    lock_en = 0; wp_pin = 0; busy = 0; blk_prot = 2'b00; addr = 16'h0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 wel", {15'b0, wel}, 16'd0);
    check("R1 permits", {14'b0, array_ok, stat_ok}, 16'd0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      busy = 0;
      if (wel !== v[23]) strobe(v[23], !v[23], 0, 0);
      lock_en = v[22]; wp_pin = v[21]; blk_prot = v[20:19];
      addr = v[18:3]; busy = v[2];
      #2;
      check($sformatf("R5-R9 vec%0d array", i), {15'b0, array_ok}, {15'b0, v[1]});
      check($sformatf("R5-R9 vec%0d stat", i), {15'b0, stat_ok}, {15'b0, v[0]});
    end
    busy = 0; blk_prot = 0; lock_en = 0; wp_pin = 0; addr = 0;

    // R3 disable clears
    strobe(1, 0, 0, 0);
    check("R2 set", {15'b0, wel}, 16'd1);
    strobe(0, 1, 0, 0);
    check("R3 clear", {15'b0, wel}, 16'd0);

    // R4 array done clears; R4 status done clears
    strobe(1, 0, 0, 0);
    strobe(0, 0, 1, 0);
    check("R4 array done", {15'b0, wel}, 16'd0);
    strobe(1, 0, 0, 0);
    strobe(0, 0, 0, 1);
    check("R4 status done", {15'b0, wel}, 16'd0);
    // R4 clear wins over set
    strobe(1, 0, 1, 0);
    check("R4 clear priority", {15'b0, wel}, 16'd0);

    // R9 enable ignored while busy
    busy = 1;
    strobe(1, 0, 0, 0);
    check("R9 enable ignored", {15'b0, wel}, 16'd0);
    busy = 0;
    strobe(1, 0, 0, 0);
    busy = 1;
    strobe(0, 1, 0, 0);
    check("R9 disable ignored", {15'b0, wel}, 16'd1);
    // R4 completion clears even while busy
    strobe(0, 0, 1, 0);
    check("R4 done during busy", {15'b0, wel}, 16'd0);
    busy = 0;

    // R10 status view
    strobe(1, 0, 0, 0);
    lock_en = 1; blk_prot = 2'b10; busy = 1;
    #2;
    check("R10 view", {8'b0, stat_view}, 16'h008B);
    busy = 0; lock_en = 0; blk_prot = 2'b01;
    #2;
    check("R10 view2", {8'b0, stat_view}, 16'h0006);

    // R1 reset clears an armed latch
    rst_n = 0;
    #2;
    check("R1 async reset", {15'b0, wel}, 16'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    finish_run();
  end
endmodule